// File: doc/BRIEF.md
# Byte-Access Sample FIFO with Thresholds

This block buffers 16-bit two's complement conversion results for a host that only has an 8-bit data path. A converter pushes whole samples on one side. The host drains each sample through a single byte-wide data port: first the low byte, then the high byte. The sample leaves storage only after its high byte has been read. The default capacity is 4096 bytes, which is 2048 samples.

A flush command clears the storage and the read sequencer, and it opens a four-write load window on the same data port. The first two byte writes set the near-empty threshold and the next two set the near-full threshold, each low byte first. The near-full threshold is counted in free bytes, not in fill level.

The block reports several flags:
- empty and full, as levels.
- near-empty and near-full, as levels compared against the loaded thresholds.
- a sticky threshold-reached event.
- a sticky data-lost event, raised when a sample arrives while the FIFO is full.

A status-read strobe clears the two sticky events.

Top module: `sample_byte_fifo`

## Requirements
- R1: After reset the FIFO is empty. full, near-full, threshold-reached and data-lost are low, near-empty is high (both thresholds reset to 0), and the read sequencer is in the low-byte phase.
- R2: Samples come out in arrival order. While the FIFO is not empty, rd_data shows the low byte (bits 7:0) of the oldest sample in the low phase and the high byte (bits 15:8) in the high phase. Each host_rd toggles the phase, and a read in the high phase removes the sample.
- R3: A host_rd while the FIFO is empty has no effect: rd_data reads 0 and the phase does not change.
- R4: The FIFO holds DEPTH_BYTES/2 samples. full is high exactly when that many are stored, and empty is high exactly when none is stored.
- R5: A sample offered while full is discarded and sets data_lost. data_lost stays set until stat_rd or flush; a new loss in the same cycle as stat_rd keeps it set.
- R6: flush discards all samples, returns the sequencer to the low phase, clears data_lost and threshold-reached, and opens a load window of four byte writes. Thresholds keep their previous values until they are rewritten. flush overrides every other input in that cycle.
- R7: In the load window, host_wr bytes are taken in this order: near-empty low byte, near-empty high byte, near-full low byte, near-full high byte. Writes outside the window are ignored.
- R8: near_full is high when the free byte count is less than or equal to the near-full threshold. The free byte count is DEPTH_BYTES minus the fill, and the fill is 2 × samples minus 1 when in the high phase.
- R9: near_empty is high when the fill byte count is less than or equal to the near-empty threshold.
- R10: thresh_hit is set one cycle after a cycle in which near_full is high. It stays set until stat_rd, and a set in the same cycle as stat_rd wins.
- R11: A push and a sample-completing read in the same cycle both take effect when the FIFO is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_valid | input | 1 | Push strobe for samp_data |
| samp_data | input | 16 | Two's complement sample |
| flush | input | 1 | FIFO reset command; opens the threshold load window |
| host_rd | input | 1 | Byte read strobe on the data port |
| host_wr | input | 1 | Byte write strobe on the data port |
| wr_data | input | 8 | Byte written on the data port |
| stat_rd | input | 1 | Status read; clears the sticky events |
| rd_data | output | 8 | Byte presented on the data port |
| empty | output | 1 | No sample stored |
| full | output | 1 | Storage full |
| near_empty | output | 1 | Fill bytes at or below the near-empty threshold |
| near_full | output | 1 | Free bytes at or below the near-full threshold |
| thresh_hit | output | 1 | Sticky threshold-reached event |
| data_lost | output | 1 | Sticky overflow event |

## Verification
The assertions assume that every strobe is a clean single-cycle level sampled at the rising edge. They also assume that flush may arrive together with any other strobe, and that the host may read past the end of the data.

The stimulus drives all inputs at the falling edge only. Random cycles mix pushes, reads, writes, status reads and occasional flushes, so that these overlaps occur and fill levels cross both thresholds. Directed passes then fill the FIFO beyond capacity, complete a read during a push while full, and drain the FIFO completely to reach the empty and full boundaries.

// File: rtl/sample_byte_fifo.sv
module sample_byte_fifo #(
  parameter int DEPTH_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        samp_valid,
  input  logic [15:0] samp_data,
  input  logic        flush,
  input  logic        host_rd,
  input  logic        host_wr,
  input  logic [7:0]  wr_data,
  input  logic        stat_rd,
  output logic [7:0]  rd_data,
  output logic        empty,
  output logic        full,
  output logic        near_empty,
  output logic        near_full,
  output logic        thresh_hit,
  output logic        data_lost
);
  localparam int SAMPLES = DEPTH_BYTES / 2;
  localparam int AW      = $clog2(SAMPLES);
  localparam int CW      = AW + 1;
  localparam int BW      = $clog2(DEPTH_BYTES) + 1;
  localparam int TW      = 16;

  logic [15:0]   mem [SAMPLES];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          rd_hi;
  logic [2:0]    load_left;
  logic [TW-1:0] ne_thr, nf_thr;
  logic [BW-1:0] fill_bytes, free_bytes;
  logic          push_ok, rd_ok, pop;

  assign empty      = (count == '0);
  assign full       = (count == CW'(SAMPLES));
  assign push_ok    = samp_valid && !full;
  assign rd_ok      = host_rd && !empty;
  assign pop        = rd_ok && rd_hi;
  assign fill_bytes = BW'({count, 1'b0}) - BW'(rd_hi);
  assign free_bytes = BW'(DEPTH_BYTES) - fill_bytes;
  assign near_full  = (TW'(free_bytes) <= nf_thr);
  assign near_empty = (TW'(fill_bytes) <= ne_thr);
  assign rd_data    = empty ? 8'h00 : (rd_hi ? mem[rd_ptr][15:8] : mem[rd_ptr][7:0]);

  always_ff @(posedge clk)
    if (push_ok && !flush) mem[wr_ptr] <= samp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      rd_hi  <= 1'b0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      rd_hi  <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop)     rd_ptr <= rd_ptr + 1'b1;
      if (rd_ok)   rd_hi  <= !rd_hi;
      count <= count + CW'(push_ok) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_left <= '0;
      ne_thr    <= '0;
      nf_thr    <= '0;
    end else if (flush) begin
      load_left <= 3'd4;
    end else if (host_wr && load_left != 3'd0) begin
      load_left <= load_left - 3'd1;
      case (load_left)
        3'd4:    ne_thr[7:0]  <= wr_data;
        3'd3:    ne_thr[15:8] <= wr_data;
        3'd2:    nf_thr[7:0]  <= wr_data;
        default: nf_thr[15:8] <= wr_data;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_lost  <= 1'b0;
      thresh_hit <= 1'b0;
    end else if (flush) begin
      data_lost  <= 1'b0;
      thresh_hit <= 1'b0;
    end else begin
      data_lost  <= (data_lost && !stat_rd) || (samp_valid && full);
      thresh_hit <= (thresh_hit && !stat_rd) || near_full;
    end
  end

  AST_FULL_XOR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R4
  AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !empty && !flush |=> rd_hi != $past(rd_hi)); // R2
  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && empty && !flush |=> $stable(rd_hi)); // R3
  AST_LOST_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    samp_valid && full && !flush |=> data_lost); // R5
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty && !rd_hi && !data_lost && !thresh_hit); // R6
  AST_LOAD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    !flush && load_left == 3'd0 |=> $stable(ne_thr) && $stable(nf_thr)); // R7
  AST_THR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    thresh_hit && !stat_rd && !flush |=> thresh_hit); // R10
  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    samp_valid && !full && rd_ok && rd_hi && !flush |=> $stable(count)); // R11
endmodule

// File: tb/sample_byte_fifo_tb_top.sv
module sample_byte_fifo_tb_top;
  localparam int CAP  = 4096;
  localparam int NSMP = CAP / 2;

  logic clk = 0, rst_n = 0;
  logic samp_valid = 0, flush = 0, host_rd = 0, host_wr = 0, stat_rd = 0;
  logic [15:0] samp_data = 0;
  logic [7:0]  wr_data = 0;
  logic [7:0]  rd_data;
  logic empty, full, near_empty, near_full, thresh_hit, data_lost;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [15:0] mq[$];
  bit mph, mlost, mthr;
  int mne, mnf, mload;

  always #5 clk = !clk;

  sample_byte_fifo #(.DEPTH_BYTES(CAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_data(samp_data),
    .flush(flush), .host_rd(host_rd), .host_wr(host_wr), .wr_data(wr_data),
    .stat_rd(stat_rd), .rd_data(rd_data), .empty(empty), .full(full),
    .near_empty(near_empty), .near_full(near_full), .thresh_hit(thresh_hit),
    .data_lost(data_lost));

  function automatic int m_fill(); return 2 * mq.size() - int'(mph); endfunction
  function automatic bit m_full(); return mq.size() == NSMP; endfunction
  function automatic bit m_nfull(); return (CAP - m_fill()) <= mnf; endfunction
  function automatic bit m_nempty(); return m_fill() <= mne; endfunction
  function automatic logic [7:0] m_rdata();
    if (mq.size() == 0) return 8'h00;
    return mph ? mq[0][15:8] : mq[0][7:0];
  endfunction

  task automatic chk(string ctx, string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, ctx, act, exp);
    end
  endtask

  task automatic check_all(string ctx);
    chk(ctx, "R4 empty", empty, mq.size() == 0);
    chk(ctx, "R4 full", full, m_full());
    chk(ctx, "R8 near_full", near_full, m_nfull());
    chk(ctx, "R9 near_empty", near_empty, m_nempty());
    chk(ctx, "R10 thresh_hit", thresh_hit, mthr);
    chk(ctx, "R5 data_lost", data_lost, mlost);
    chk(ctx, "R2 rd_data", rd_data, m_rdata());
  endtask

  task automatic model_update();
    bit was_full = m_full();
    bit was_nf = m_nfull();
    if (flush) begin
      mq.delete(); mph = 0; mload = 4; mlost = 0; mthr = 0;
      return;
    end
    mlost = (mlost && !stat_rd) || (samp_valid && was_full);
    mthr  = (mthr && !stat_rd) || was_nf;
    if (host_rd && mq.size() != 0) begin
      if (mph) void'(mq.pop_front());
      mph = !mph;
    end
    if (samp_valid && !was_full) mq.push_back(samp_data);
    if (host_wr && mload > 0) begin
      case (mload)
        4: mne[7:0]  = wr_data;
        3: mne[15:8] = wr_data;
        2: mnf[7:0]  = wr_data;
        default: mnf[15:8] = wr_data;
      endcase
      mload--;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    samp_valid = 0; flush = 0; host_rd = 0; host_wr = 0; stat_rd = 0;
  endtask

  task automatic load_thr(int ne, int nf);
    flush = 1; step(); check_all("R6 flush");
    for (int i = 0; i < 4; i++) begin
      host_wr = 1;
      wr_data = (i == 0) ? ne[7:0] : (i == 1) ? ne[15:8] : (i == 2) ? nf[7:0] : nf[15:8];
      step(); check_all("R7 load");
    end
  endtask

  initial begin
    mne = 0; mnf = 0; mload = 0; mph = 0; mlost = 0; mthr = 0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_all("R1 reset");

    host_rd = 1; step(); check_all("R3 empty read");
    samp_valid = 1; samp_data = 16'hA55A; step(); check_all("R3 after push");
    chk("R3 phase kept", "R3", rd_data, 8'h5A);

    load_thr(16'h0010, 16'h0F00);
    host_wr = 1; wr_data = 8'hFF; step(); check_all("R7 write past window");
    samp_valid = 1; samp_data = 16'h8001; step(); check_all("R7 thresholds kept");

    for (int c = 0; c < 3000; c++) begin
      samp_valid = ($urandom % 4) != 0;
      samp_data  = 16'($urandom);
      host_rd    = ($urandom % 2) == 0;
      host_wr    = ($urandom % 4) == 0;
      wr_data    = 8'($urandom);
      stat_rd    = ($urandom % 16) == 0;
      flush      = ($urandom % 400) == 0;
      step(); check_all("random");
    end

    load_thr(16'h0100, 16'h0040);
    for (int i = 0; i < NSMP + 3; i++) begin
      samp_valid = 1; samp_data = 16'(i * 3 + 16'h8000);
      step(); check_all("R4 fill");
    end
    stat_rd = 1; samp_valid = 1; step(); check_all("R5 loss with status read");
    stat_rd = 1; step(); check_all("R5 status read clears");
    host_rd = 1; step(); check_all("R11 low byte");
    host_rd = 1; samp_valid = 1; samp_data = 16'h1234; step(); check_all("R11 pop while full");
    host_rd = 1; samp_valid = 1; samp_data = 16'h4321; step(); check_all("R11 push and read");
    host_rd = 1; samp_valid = 1; samp_data = 16'h7777; step(); check_all("R11 push and pop");
    stat_rd = 1; step(); check_all("R10 status read");
    while (mq.size() != 0) begin
      host_rd = 1; step(); check_all("R2 drain");
    end
    host_rd = 1; step(); check_all("R3 read past end");
    flush = 1; samp_valid = 1; host_rd = 1; step(); check_all("R6 flush priority");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule